// File: doc/BRIEF.md
# Audio Interface Interrupt Status Unit

This block gathers the event and status conditions of one serial audio sub-block and turns them into a single interrupt request. It keeps a status flag for each of seven sources and exposes three registers on a simple register bus: an interrupt-mask register, a read-only status register and a write-one-to-clear register. The transfer engine drives single-cycle event pulses, the FIFO side supplies its fill count and threshold, and the configuration side supplies mode qualifiers (master or slave, transmitter or receiver, protocol mode, clock-divider bypass).

The FIFO-request source is a live level that follows the threshold comparison and the transfer direction. The other six sources are sticky: a qualified event pulse sets the flag, and software clears it by writing 1 to the matching clear bit. Each event is accepted only in the operating modes where it has meaning. Otherwise the pulse is dropped and the flag stays clear. The interrupt line is the registered OR of all flags ANDed with their mask bits.

Bit positions are shared by the mask, status and clear registers: bit 0 FIFO request, bit 1 overrun/underrun, bit 2 early frame sync, bit 3 late frame sync, bit 4 codec not ready, bit 5 mute detect, bit 6 clock-configuration error. Register addresses: 0 mask (read/write), 1 status (read-only), 2 clear (write-only, reads 0). Protocol mode encoding: 0 free, 1 SPDIF, 2 AC'97, 3 free (treated like 0).

Top module: `audio_irq_unit`

## Requirements
- R1: After synchronous active-low reset, every flag, every mask bit and irq_o are 0.
- R2: Status bit 0 is a live FIFO request with no clear: as a transmitter (mode_tx=1) it is 1 when fifo_fill <= fifo_thresh, as a receiver it is 1 when fifo_fill >= fifo_thresh, and it follows those inputs in the same cycle.
- R3: A qualified event pulse sets its sticky flag (bits 1 to 6) at the clock edge where it is sampled, and the flag holds until cleared.
- R4: Writing to address 2 clears each flag whose data bit is 1 at that edge. Data bits that are 0 leave their flags unchanged, and bit 0 has no effect.
- R5: When an event pulse and a clear of the same flag fall in the same cycle, the flag is set after the edge.
- R6: Early and late frame-sync events (bits 2, 3) set their flags only in slave mode with protocol mode other than 1 (SPDIF) and 2 (AC'97).
- R7: The codec-not-ready event (bit 4) sets its flag only in slave mode with protocol mode 2 (AC'97).
- R8: The mute event (bit 5) sets its flag only when the block is a receiver (mode_tx=0).
- R9: The clock-configuration event (bit 6) sets its flag only in master mode with mode_div_bypass=0.
- R10: The overrun/underrun event (bit 1) sets its flag in master and slave modes and in both directions.
- R11: irq_o equals, one cycle later, the OR over all seven bits of (status AND mask).
- R12: Address 0 reads back bits 6:0 last written to it, with upper bits 0. Writes to address 1 change nothing, and address 2 and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| fifo_fill | input | 5 | Current FIFO fill count |
| fifo_thresh | input | 5 | FIFO request threshold |
| mode_master | input | 1 | 1 = master, 0 = slave |
| mode_tx | input | 1 | 1 = transmitter, 0 = receiver |
| mode_proto | input | 2 | Protocol mode: 0 free, 1 SPDIF, 2 AC'97, 3 free |
| mode_div_bypass | input | 1 | Clock-divider bypass control |
| evt_xrun | input | 1 | Overrun/underrun event pulse |
| evt_early_fs | input | 1 | Early frame-sync event pulse |
| evt_late_fs | input | 1 | Late frame-sync event pulse |
| evt_codec_nrdy | input | 1 | Codec-not-ready event pulse |
| evt_mute | input | 1 | Mute-detect event pulse |
| evt_clkcfg | input | 1 | Clock-configuration error event pulse |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Each gated event is fired under every mode combination that should accept it and under at least one that should reject it. This shows the mode qualifiers are decoded for the right source and not swapped between sources. The FIFO request is driven at, above and below the threshold in both directions, which tells the inclusive comparison apart from a strict one and catches a swapped direction. Clears are tried with all-zero data, with only bit 0, with one bit out of two set flags, and in the same cycle as an event, which separates per-bit clearing and event priority from a global clear. The interrupt is exercised with a mask that excludes a set flag and then includes one, so masking and the one-cycle register delay are each visible on irq_o.

// File: rtl/aiu_pkg.sv
// Shared definitions for the audio interrupt status unit.
// Assumes bit positions are common to mask, status and clear registers.
package aiu_pkg;

    localparam int NSRC = 7;

    // Source positions within the mask, status and clear registers.
    localparam int SRC_FIFO       = 0;
    localparam int SRC_XRUN       = 1;
    localparam int SRC_EARLY_FS   = 2;
    localparam int SRC_LATE_FS    = 3;
    localparam int SRC_CODEC_NRDY = 4;
    localparam int SRC_MUTE       = 5;
    localparam int SRC_CLKCFG     = 6;

    typedef enum logic [1:0] {
        PROTO_FREE  = 2'd0,
        PROTO_SPDIF = 2'd1,
        PROTO_AC97  = 2'd2,
        PROTO_ALT   = 2'd3
    } proto_e;

    typedef struct packed {
        logic   master;
        logic   tx;
        proto_e proto;
        logic   div_bypass;
    } mode_t;

endpackage

// File: rtl/aiu_fifo_req.sv
// Live FIFO request level.
// Compares the fill count against the threshold in the direction given by
// the transfer mode. Purely combinational; no state is kept.
module aiu_fifo_req #(
    parameter int FW = 5
) (
    input  logic          tx_i,
    input  logic [FW-1:0] fill_i,
    input  logic [FW-1:0] thresh_i,
    output logic          req_o
);

    // Transmitter wants data when low, receiver wants draining when high.
    always_comb begin
        if (tx_i) begin
            req_o = (fill_i <= thresh_i);
        end else begin
            req_o = (fill_i >= thresh_i);
        end
    end

endmodule

// File: rtl/aiu_mode_gate.sv
// Mode qualification of event pulses.
// Passes each raw event only when the operating mode gives it meaning.
// Assumes events are single-cycle pulses from the transfer engine.
module aiu_mode_gate
    import aiu_pkg::*;
(
    input  aiu_pkg::mode_t    mode_i,
    input  logic [NSRC-1:1]   evt_i,
    output logic [NSRC-1:1]   qual_o
);

    logic slave_plain;
    logic slave_ac97;

    // Common mode terms shared by several sources.
    always_comb begin
        slave_plain = !mode_i.master &&
                      (mode_i.proto != PROTO_AC97) &&
                      (mode_i.proto != PROTO_SPDIF);
        slave_ac97  = !mode_i.master && (mode_i.proto == PROTO_AC97);
    end

    // Per-source gating of the raw pulses.
    always_comb begin
        qual_o                 = '0;
        qual_o[SRC_XRUN]       = evt_i[SRC_XRUN];
        qual_o[SRC_EARLY_FS]   = evt_i[SRC_EARLY_FS] && slave_plain;
        qual_o[SRC_LATE_FS]    = evt_i[SRC_LATE_FS] && slave_plain;
        qual_o[SRC_CODEC_NRDY] = evt_i[SRC_CODEC_NRDY] && slave_ac97;
        qual_o[SRC_MUTE]       = evt_i[SRC_MUTE] && !mode_i.tx;
        qual_o[SRC_CLKCFG]     = evt_i[SRC_CLKCFG] && mode_i.master &&
                                 !mode_i.div_bypass;
    end

endmodule

// File: rtl/aiu_flag_bank.sv
// Bank of sticky status flags.
// Each flag is set by its qualified event and cleared by its clear strobe;
// a set in the same cycle as a clear wins. Synchronous active-low reset.
module aiu_flag_bank #(
    parameter int NF = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_i,
    input  logic [NF-1:0] clr_i,
    output logic [NF-1:0] flag_o
);

    for (genvar g = 0; g < NF; g++) begin : g_flag
        // One sticky bit: set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_o[g] <= 1'b0;
            end else if (set_i[g]) begin
                flag_o[g] <= 1'b1;
            end else if (clr_i[g]) begin
                flag_o[g] <= 1'b0;
            end
        end

        AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> flag_o[g]); // R3
        AST_CLR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !set_i[g]) |=> !flag_o[g]); // R4
        AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i[g] && !set_i[g]) |=> $stable(flag_o[g])); // R3
    end

endmodule

// File: rtl/aiu_regs.sv
// Register bus front end.
// Holds the mask register, decodes clear writes into strobes and muxes the
// read data. Reads are combinational on the address; writes take effect at
// the clock edge where bus_we is sampled.
module aiu_regs #(
    parameter int AW        = 4,
    parameter int DW        = 32,
    parameter int NS        = 7,
    parameter int ADDR_MASK = 0,
    parameter int ADDR_STAT = 1,
    parameter int ADDR_CLR  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    input  logic [NS-1:0] status_i,
    output logic [NS-1:0] mask_o,
    output logic [NS-1:1] clr_o
);

    logic hit_mask;
    logic hit_stat;
    logic hit_clr;

    // Address decode.
    always_comb begin
        hit_mask = (addr_i == AW'(ADDR_MASK));
        hit_stat = (addr_i == AW'(ADDR_STAT));
        hit_clr  = (addr_i == AW'(ADDR_CLR));
    end

    // Mask register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_o <= '0;
        end else if (we_i && hit_mask) begin
            mask_o <= wdata_i[NS-1:0];
        end
    end

    // Clear strobes: one-cycle, only for sticky bits.
    always_comb begin
        clr_o = '0;
        if (we_i && hit_clr) begin
            clr_o = wdata_i[NS-1:1];
        end
    end

    // Read data mux.
    always_comb begin
        rdata_o = '0;
        if (hit_mask) begin
            rdata_o[NS-1:0] = mask_o;
        end else if (hit_stat) begin
            rdata_o[NS-1:0] = status_i;
        end
    end

    AST_MASK_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_i && hit_mask) |=> $stable(mask_o)); // R12

endmodule

// File: rtl/audio_irq_unit.sv
// Audio interface interrupt status unit (top).
// Collects mode-qualified events into sticky flags, adds the live FIFO
// request, applies the mask and registers the interrupt line.
// Assumes all inputs are synchronous to clk.
module audio_irq_unit
    import aiu_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 32,
    parameter int FW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [FW-1:0] fifo_fill,
    input  logic [FW-1:0] fifo_thresh,
    input  logic          mode_master,
    input  logic          mode_tx,
    input  logic [1:0]    mode_proto,
    input  logic          mode_div_bypass,
    input  logic          evt_xrun,
    input  logic          evt_early_fs,
    input  logic          evt_late_fs,
    input  logic          evt_codec_nrdy,
    input  logic          evt_mute,
    input  logic          evt_clkcfg,
    output logic          irq_o
);

    localparam int NSTICKY = NSRC - 1;

    mode_t             mode;
    logic [NSRC-1:1]   evt_raw;
    logic [NSRC-1:1]   evt_qual;
    logic [NSRC-1:1]   clr_strobe;
    logic [NSTICKY-1:0] sticky;
    logic              fifo_req;
    logic [NSRC-1:0]   status;
    logic [NSRC-1:0]   mask;

    // Pack mode and event inputs.
    always_comb begin
        mode.master     = mode_master;
        mode.tx         = mode_tx;
        mode.proto      = proto_e'(mode_proto);
        mode.div_bypass = mode_div_bypass;
        evt_raw[SRC_XRUN]       = evt_xrun;
        evt_raw[SRC_EARLY_FS]   = evt_early_fs;
        evt_raw[SRC_LATE_FS]    = evt_late_fs;
        evt_raw[SRC_CODEC_NRDY] = evt_codec_nrdy;
        evt_raw[SRC_MUTE]       = evt_mute;
        evt_raw[SRC_CLKCFG]     = evt_clkcfg;
    end

    aiu_fifo_req #(.FW(FW)) i_fifo_req (
        .tx_i     (mode_tx),
        .fill_i   (fifo_fill),
        .thresh_i (fifo_thresh),
        .req_o    (fifo_req)
    );

    aiu_mode_gate i_mode_gate (
        .mode_i (mode),
        .evt_i  (evt_raw),
        .qual_o (evt_qual)
    );

    aiu_flag_bank #(.NF(NSTICKY)) i_flag_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (evt_qual),
        .clr_i  (clr_strobe),
        .flag_o (sticky)
    );

    // Unmasked status view.
    always_comb begin
        status = {sticky, fifo_req};
    end

    aiu_regs #(.AW(AW), .DW(DW), .NS(NSRC)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (bus_we),
        .addr_i   (bus_addr),
        .wdata_i  (bus_wdata),
        .rdata_o  (bus_rdata),
        .status_i (status),
        .mask_o   (mask),
        .clr_o    (clr_strobe)
    );

    // Registered interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= |(status & mask);
        end
    end

    AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status & mask)) |=> irq_o); // R11
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(status & mask)) |=> !irq_o); // R11
    AST_MUTE_TX_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_tx && !status[SRC_MUTE]) |=> !status[SRC_MUTE]); // R8
    AST_LATE_FS_MASTER_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_master && !status[SRC_LATE_FS]) |=> !status[SRC_LATE_FS]); // R6
    AST_CLKCFG_SLAVE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_master && !status[SRC_CLKCFG]) |=> !status[SRC_CLKCFG]); // R9
    AST_CODEC_NONAC97_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_proto != 2'd2) && !status[SRC_CODEC_NRDY]) |=> !status[SRC_CODEC_NRDY]); // R7

endmodule

// File: tb/test_audio_irq_unit.sv
module test_audio_irq_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  addr = 4'd1;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [4:0]  fill = 5'd5;
    logic [4:0]  thr = 5'd2;
    logic        master = 1'b0;
    logic        tx = 1'b1;
    logic [1:0]  proto = 2'd0;
    logic        bypass = 1'b0;
    logic [6:1]  ev = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit started = 0;

    bit [6:0] m_flag = '0;
    bit [6:0] m_mask = '0;
    bit       m_irq  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    audio_irq_unit i_audio_irq_unit (
        .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .fifo_fill(fill),
        .fifo_thresh(thr), .mode_master(master), .mode_tx(tx),
        .mode_proto(proto), .mode_div_bypass(bypass),
        .evt_xrun(ev[1]), .evt_early_fs(ev[2]), .evt_late_fs(ev[3]),
        .evt_codec_nrdy(ev[4]), .evt_mute(ev[5]), .evt_clkcfg(ev[6]),
        .irq_o(irq)
    );

    function automatic bit fifo_live();
        if (tx) return fill <= thr;
        return fill >= thr;
    endfunction

    function automatic bit [31:0] model_read();
        bit [31:0] r = '0;
        if (addr == 4'd0) r[6:0] = m_mask;
        else if (addr == 4'd1) r[6:0] = {m_flag[6:1], fifo_live()};
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, updated on every edge.
    always @(posedge clk) begin
        bit [6:0] st;
        bit [6:0] nf;
        started = 1;
        if (!rst_n) begin
            m_flag = '0; m_mask = '0; m_irq = 0;
        end else begin
            st = m_flag; st[0] = fifo_live();
            m_irq = |(st & m_mask);
            nf = m_flag;
            if (we && addr == 4'd2)
                for (int i = 1; i < 7; i++) if (wdata[i]) nf[i] = 0;
            if (ev[1]) nf[1] = 1;
            if (ev[2] && !master && proto != 2'd1 && proto != 2'd2) nf[2] = 1;
            if (ev[3] && !master && proto != 2'd1 && proto != 2'd2) nf[3] = 1;
            if (ev[4] && !master && proto == 2'd2) nf[4] = 1;
            if (ev[5] && !tx) nf[5] = 1;
            if (ev[6] && master && !bypass) nf[6] = 1;
            nf[0] = 0;
            m_flag = nf;
            if (we && addr == 4'd0) m_mask = wdata[6:0];
        end
    end

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (started) begin
            check(irq === m_irq, "R11 irq per-cycle", {31'd0, irq}, {31'd0, m_irq});
            check(rdata === model_read(), "R3 read per-cycle", rdata, model_read());
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        step();
        we = 1'b0; addr = 4'd1; wdata = '0;
    endtask

    task automatic pulse(input int idx);
        ev[idx] = 1'b1;
        step();
        ev = '0;
    endtask

    task automatic expect_rd(input logic [3:0] a, input logic [31:0] m,
                             input logic [31:0] exp, input string tag);
        addr = a;
        @(negedge clk);
        check((rdata & m) === exp, tag, rdata & m, exp);
        step();
        addr = 4'd1;
    endtask

    task automatic expect_irq_next(input bit exp, input string tag);
        step();
        @(negedge clk);
        check(irq === exp, tag, {31'd0, irq}, {31'd0, exp});
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        // R1 reset state
        expect_rd(4'd0, 32'h7F, 32'h0, "R1 mask after reset");
        expect_rd(4'd1, 32'h7F, 32'h0, "R1 status after reset");
        check(irq === 1'b0, "R1 irq after reset", {31'd0, irq}, 32'd0);
        // R12 register access
        wr(4'd0, 32'hFFFF_FFFF);
        expect_rd(4'd0, 32'hFFFF_FFFF, 32'h7F, "R12 mask readback");
        wr(4'd0, 32'h0);
        wr(4'd1, 32'h7F);
        expect_rd(4'd1, 32'h7F, 32'h0, "R12 status write ignored");
        expect_rd(4'd2, 32'hFFFF_FFFF, 32'h0, "R12 clear reads zero");
        // R2 FIFO request level
        fill = 5'd2;
        expect_rd(4'd1, 32'h1, 32'h1, "R2 tx at threshold");
        fill = 5'd3;
        expect_rd(4'd1, 32'h1, 32'h0, "R2 tx above threshold");
        tx = 1'b0;
        expect_rd(4'd1, 32'h1, 32'h1, "R2 rx above threshold");
        fill = 5'd1;
        expect_rd(4'd1, 32'h1, 32'h0, "R2 rx below threshold");
        tx = 1'b1; fill = 5'd5;
        // R10 overrun in both modes
        master = 1'b1; pulse(1);
        expect_rd(4'd1, 32'h2, 32'h2, "R10 xrun master");
        wr(4'd2, 32'h2);
        expect_rd(4'd1, 32'h2, 32'h0, "R4 xrun cleared");
        master = 1'b0; tx = 1'b0; pulse(1); tx = 1'b1;
        expect_rd(4'd1, 32'h2, 32'h2, "R10 xrun slave rx");
        wr(4'd2, 32'h2);
        // R6 frame sync gating
        pulse(2); pulse(3);
        expect_rd(4'd1, 32'hC, 32'hC, "R6 slave free protocol");
        wr(4'd2, 32'hC);
        expect_rd(4'd1, 32'hC, 32'h0, "R4 frame sync cleared");
        master = 1'b1; pulse(2); pulse(3);
        expect_rd(4'd1, 32'hC, 32'h0, "R6 master ignored");
        master = 1'b0; proto = 2'd2; pulse(2); pulse(3);
        expect_rd(4'd1, 32'hC, 32'h0, "R6 AC97 ignored");
        proto = 2'd1; pulse(2); pulse(3);
        expect_rd(4'd1, 32'hC, 32'h0, "R6 SPDIF ignored");
        proto = 2'd3; pulse(3);
        expect_rd(4'd1, 32'hC, 32'h8, "R6 protocol 3 accepted");
        wr(4'd2, 32'h8);
        // R7 codec not ready
        proto = 2'd2; pulse(4);
        expect_rd(4'd1, 32'h10, 32'h10, "R7 slave AC97");
        wr(4'd2, 32'h10);
        proto = 2'd0; pulse(4);
        expect_rd(4'd1, 32'h10, 32'h0, "R7 free protocol ignored");
        proto = 2'd2; master = 1'b1; pulse(4);
        expect_rd(4'd1, 32'h10, 32'h0, "R7 master ignored");
        master = 1'b0; proto = 2'd0;
        // R8 mute
        tx = 1'b0; pulse(5);
        expect_rd(4'd1, 32'h20, 32'h20, "R8 receiver");
        wr(4'd2, 32'h20);
        tx = 1'b1; pulse(5);
        expect_rd(4'd1, 32'h20, 32'h0, "R8 transmitter ignored");
        // R9 clock configuration
        master = 1'b1; pulse(6);
        expect_rd(4'd1, 32'h40, 32'h40, "R9 master no bypass");
        wr(4'd2, 32'h40);
        bypass = 1'b1; pulse(6);
        expect_rd(4'd1, 32'h40, 32'h0, "R9 bypass ignored");
        master = 1'b0; bypass = 1'b0; pulse(6);
        expect_rd(4'd1, 32'h40, 32'h0, "R9 slave ignored");
        // R4 per-bit clear
        pulse(1); tx = 1'b0; pulse(5); tx = 1'b1;
        wr(4'd2, 32'h0);
        expect_rd(4'd1, 32'h7E, 32'h22, "R4 zero write no effect");
        wr(4'd2, 32'h1);
        expect_rd(4'd1, 32'h7E, 32'h22, "R4 bit0 no effect");
        wr(4'd2, 32'h2);
        expect_rd(4'd1, 32'h7E, 32'h20, "R4 single bit clear");
        wr(4'd2, 32'h20);
        expect_rd(4'd1, 32'h7E, 32'h0, "R4 all cleared");
        // R5 event beats clear
        ev[1] = 1'b1; we = 1'b1; addr = 4'd2; wdata = 32'h2;
        step();
        ev = '0; we = 1'b0; addr = 4'd1; wdata = '0;
        expect_rd(4'd1, 32'h2, 32'h2, "R5 set wins over clear");
        wr(4'd2, 32'h2);
        // R11 masked interrupt
        wr(4'd0, 32'h20);
        pulse(1);
        expect_irq_next(1'b0, "R11 masked flag no irq");
        tx = 1'b0; pulse(5); tx = 1'b1;
        @(negedge clk);
        check(irq === 1'b0, "R11 irq delayed one cycle", {31'd0, irq}, 32'd0);
        step();
        @(negedge clk);
        check(irq === 1'b1, "R11 enabled flag irq", {31'd0, irq}, 32'd1);
        step();
        wr(4'd2, 32'h22);
        expect_irq_next(1'b0, "R11 irq drops after clear");
        wr(4'd0, 32'h1); fill = 5'd2;
        expect_irq_next(1'b1, "R11 fifo request irq");
        fill = 5'd5;
        expect_irq_next(1'b0, "R11 fifo request gone");
        repeat (2) step();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule